// File: doc/BRIEF.md
# Multi-Word Transfer Sequencer with Byte-Order Mapping

This block takes one multi-word request and issues it as a run of word-sized memory beats. The request can be a paired-word load or store, or a counted block load or store. Every beat goes to a word-aligned address, and each following beat is four bytes above the one before it. Each word crosses a byte-lane mapper on its way through. An order-select bit picks the mapping: either the lowest memory byte holds the register's least significant byte, or it holds the register's most significant byte. Loads and stores use the same mapping.

The register side presents a request with these fields: a start address, a word count, a direction, a paired-word flag, the byte-order bit and a strict-alignment enable. During a store, the block publishes the current word index so the register side can supply the matching store word. During a load, the block returns mapped words together with the same index. An alignment failure under strict checking ends the request with a fault pulse and a status code, and no memory access is made. A zero word count also ends the request that way. The memory side uses a per-beat valid/ready handshake.

Top module: `xfer_seq`

## Requirements
- R1: An accepted request of N words produces exactly N memory beats. Beat i carries address base+4*i, and `word_idx` equals i during that beat. Here base is the start address with bits [1:0] cleared.
- R2: `mem_addr[1:0]` is zero whenever `mem_valid` is high.
- R3: If strict alignment is on and start address bits [1:0] are nonzero, no beat is issued. In the cycle after acceptance, `fault` pulses for one cycle with `fault_code` = 4'h1.
- R4: If strict alignment is off, a misaligned start address runs normally from the cleared base address.
- R5: With `req_big` = 0, memory byte lane k (`mem_wdata[8k+7:8k]`, address +k) carries register byte k.
- R6: With `req_big` = 1, memory byte lane k carries register byte 3-k. So register bits 31:24 go to the lowest address.
- R7: A load beat that completes raises `ld_valid` in the same cycle. `ld_data` then holds `mem_rdata` passed through the mapping of R5/R6 for the request's byte order.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr`, `word_idx` and `mem_wdata` stay unchanged in the next cycle.
- R9: `done` pulses for one cycle in the cycle after the final beat completes. `req_ready` is high in that cycle.
- R10: With `req_pair` = 1, the count is 2, whatever `req_count` holds.
- R11: A request with count 0 (and no alignment fault) issues no beat. In the cycle after acceptance, it pulses `fault` with `fault_code` = 4'h2. The alignment fault takes priority over this one.
- R12: `req_ready` is low while a run is in progress, and a `req_valid` presented then has no effect on the beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_addr | input | AW | Start byte address |
| req_count | input | CW | Number of words |
| req_write | input | 1 | 1 = store, 0 = load |
| req_pair | input | 1 | Paired-word request, count forced to 2 |
| req_big | input | 1 | Byte order: 0 little, 1 big |
| req_strict | input | 1 | Strict alignment check enable |
| word_idx | output | CW | Index of the current word |
| reg_wdata | input | 32 | Store word for index `word_idx` |
| ld_valid | output | 1 | Load word returned this cycle |
| ld_data | output | 32 | Mapped load word |
| mem_valid | output | 1 | Memory beat valid |
| mem_ready | input | 1 | Memory accepts beat |
| mem_addr | output | AW | Word-aligned beat address |
| mem_write | output | 1 | Beat is a store |
| mem_wdata | output | 32 | Mapped store word |
| mem_rdata | input | 32 | Load word from memory, valid with ready |
| done | output | 1 | Request completed |
| fault | output | 1 | Request aborted |
| fault_code | output | 4 | Abort reason: 1 alignment, 2 empty |

## Verification
The assertions check several properties on every cycle: beat addresses are word-aligned, each following beat steps by four bytes, nothing moves while a beat is stalled, the two outcome pulses never coincide and no beat runs during a fault, and the store lanes are mapped for each byte order. Other behaviour depends on the request as a whole, and only the bench's scenarios can show it. This covers the exact beat count, the paired-word override of the count, the choice of fault code and the priority between codes, the latency of the done and fault pulses, and loaded words that return correctly mapped from a memory model.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int FCODE_W    = 4;

  localparam logic [FCODE_W-1:0] FLT_NONE  = 4'h0;
  localparam logic [FCODE_W-1:0] FLT_ALIGN = 4'h1;
  localparam logic [FCODE_W-1:0] FLT_EMPTY = 4'h2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= 2'b00;
    end else begin
      pipe_q <= {pipe_q[0], 1'b1};
    end
  end

  assign rst_n_sync = pipe_q[1];
endmodule

// File: rtl/xfer_lane_map.sv
module xfer_lane_map #(
  parameter int LANES = 4
) (
  input  logic               big,
  input  logic [8*LANES-1:0] in_word,
  output logic [8*LANES-1:0] out_word
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign out_word[8*k +: 8] = big ? in_word[8*(LANES-1-k) +: 8]
                                    : in_word[8*k +: 8];
  end
endmodule

// File: rtl/xfer_align_chk.sv
module xfer_align_chk
  import xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic [AW-1:0]      addr,
  input  logic [CW-1:0]      count,
  input  logic               pair,
  input  logic               strict,
  output logic [AW-1:0]      base,
  output logic [CW-1:0]      eff_count,
  output logic               reject,
  output logic [FCODE_W-1:0] code
);
  logic misaligned;

  always_comb begin
    base       = {addr[AW-1:2], 2'b00};
    eff_count  = pair ? CW'(2) : count;
    misaligned = strict && (addr[1:0] != 2'b00);
    if (misaligned) begin
      reject = 1'b1;
      code   = FLT_ALIGN;
    end else if (eff_count == '0) begin
      reject = 1'b1;
      code   = FLT_EMPTY;
    end else begin
      reject = 1'b0;
      code   = FLT_NONE;
    end
  end
endmodule

// File: rtl/xfer_beat_ctrl.sv
module xfer_beat_ctrl
  import xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] start_base,
  input  logic [CW-1:0] start_count,
  input  logic          start_write,
  input  logic          start_big,
  input  logic          beat_ready,
  output logic          busy,
  output logic [AW-1:0] beat_addr,
  output logic [CW-1:0] beat_idx,
  output logic          cur_write,
  output logic          cur_big,
  output logic          done
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_e    state_q, state_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [CW-1:0] idx_q, idx_d;
  logic [CW-1:0] last_q, last_d;
  logic          wr_q, wr_d;
  logic          big_q, big_d;
  logic          done_q, done_d;
  logic          load_en;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    last_d  = last_q;
    wr_d    = wr_q;
    big_d   = big_q;
    done_d  = 1'b0;
    load_en = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = ST_RUN;
          addr_d  = start_base;
          idx_d   = '0;
          last_d  = start_count - CW'(1);
          wr_d    = start_write;
          big_d   = start_big;
        end
      end
      ST_RUN: begin
        if (beat_ready) begin
          load_en = 1'b1;
          if (idx_q == last_q) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            idx_d  = idx_q + CW'(1);
            addr_d = addr_q + STEP;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      idx_q  <= '0;
      last_q <= '0;
      wr_q   <= 1'b0;
      big_q  <= 1'b0;
    end else if (load_en) begin
      addr_q <= addr_d;
      idx_q  <= idx_d;
      last_q <= last_d;
      wr_q   <= wr_d;
      big_q  <= big_d;
    end
  end

  assign busy      = (state_q == ST_RUN);
  assign beat_addr = addr_q;
  assign beat_idx  = idx_q;
  assign cur_write = wr_q;
  assign cur_big   = big_q;
  assign done      = done_q;
endmodule

// File: rtl/xfer_seq.sv
module xfer_seq
  import xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [AW-1:0]      req_addr,
  input  logic [CW-1:0]      req_count,
  input  logic               req_write,
  input  logic               req_pair,
  input  logic               req_big,
  input  logic               req_strict,
  output logic [CW-1:0]      word_idx,
  input  logic [31:0]        reg_wdata,
  output logic               ld_valid,
  output logic [31:0]        ld_data,
  output logic               mem_valid,
  input  logic               mem_ready,
  output logic [AW-1:0]      mem_addr,
  output logic               mem_write,
  output logic [31:0]        mem_wdata,
  input  logic [31:0]        mem_rdata,
  output logic               done,
  output logic               fault,
  output logic [FCODE_W-1:0] fault_code
);
  logic               rst_n_i;
  logic               busy;
  logic               accept;
  logic               start;
  logic [AW-1:0]      chk_base;
  logic [CW-1:0]      chk_count;
  logic               chk_reject;
  logic [FCODE_W-1:0] chk_code;
  logic               cur_write;
  logic               cur_big;
  logic               fault_q, fault_d;
  logic [FCODE_W-1:0] code_q, code_d;

  xfer_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  xfer_align_chk #(.AW(AW), .CW(CW)) u_align_chk (
    .addr      (req_addr),
    .count     (req_count),
    .pair      (req_pair),
    .strict    (req_strict),
    .base      (chk_base),
    .eff_count (chk_count),
    .reject    (chk_reject),
    .code      (chk_code)
  );

  assign req_ready = !busy;
  assign accept    = req_valid && req_ready;
  assign start     = accept && !chk_reject;

  xfer_beat_ctrl #(.AW(AW), .CW(CW)) u_beat_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .start       (start),
    .start_base  (chk_base),
    .start_count (chk_count),
    .start_write (req_write),
    .start_big   (req_big),
    .beat_ready  (mem_ready),
    .busy        (busy),
    .beat_addr   (mem_addr),
    .beat_idx    (word_idx),
    .cur_write   (cur_write),
    .cur_big     (cur_big),
    .done        (done)
  );

  xfer_lane_map #(.LANES(WORD_BYTES)) u_map_store (
    .big      (cur_big),
    .in_word  (reg_wdata),
    .out_word (mem_wdata)
  );

  xfer_lane_map #(.LANES(WORD_BYTES)) u_map_load (
    .big      (cur_big),
    .in_word  (mem_rdata),
    .out_word (ld_data)
  );

  assign mem_valid = busy;
  assign mem_write = cur_write;
  assign ld_valid  = busy && mem_ready && !cur_write;

  always_comb begin
    fault_d = accept && chk_reject;
    code_d  = code_q;
    if (accept && chk_reject) begin
      code_d = chk_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fault_q <= 1'b0;
      code_q  <= FLT_NONE;
    end else begin
      fault_q <= fault_d;
      code_q  <= code_d;
    end
  end

  assign fault      = fault_q;
  assign fault_code = code_q;
endmodule

// File: rtl/xfer_seq_chk.sv
module xfer_seq_chk #(
  parameter int AW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] word_idx,
  input logic [31:0]   mem_wdata,
  input logic [31:0]   reg_wdata,
  input logic          mem_write,
  input logic          cur_big,
  input logic          req_ready,
  input logic          done,
  input logic          fault
);
  p_addr_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_addr[1:0] == 2'b00));

  p_addr_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) ##1 mem_valid |->
      (mem_addr == $past(mem_addr) + AW'(4)) && (word_idx == $past(word_idx) + CW'(1)));

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (mem_valid && $stable(mem_addr) && $stable(word_idx)));

  p_no_beat_on_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (!mem_valid && req_ready));

  p_done_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (req_ready && !mem_valid && !fault));

  p_busy_not_ready_r12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !req_ready);

  p_outcome_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault}));

  p_lane_little_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && !cur_big) |->
      (mem_wdata[7:0] == reg_wdata[7:0]) && (mem_wdata[31:24] == reg_wdata[31:24]));

  p_lane_big_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_write && cur_big) |->
      (mem_wdata[7:0] == reg_wdata[31:24]) && (mem_wdata[15:8] == reg_wdata[23:16]));
endmodule

bind xfer_seq xfer_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_valid (mem_valid),
  .mem_ready (mem_ready),
  .mem_addr  (mem_addr),
  .word_idx  (word_idx),
  .mem_wdata (mem_wdata),
  .reg_wdata (reg_wdata),
  .mem_write (mem_write),
  .cur_big   (cur_big),
  .req_ready (req_ready),
  .done      (done),
  .fault     (fault)
);

// File: tb/xfer_seq_tb.sv
module xfer_seq_tb;
  localparam int AW = 32;
  localparam int CW = 4;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [CW-1:0] req_count;
  logic          req_write, req_pair, req_big, req_strict;
  logic [CW-1:0] word_idx;
  logic [31:0]   reg_wdata;
  logic          ld_valid;
  logic [31:0]   ld_data;
  logic          mem_valid, mem_ready, mem_write;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic          done, fault;
  logic [3:0]    fault_code;

  logic [31:0] regs [16];
  logic [31:0] memw [64];

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  xfer_seq #(.AW(AW), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_count(req_count),
    .req_write(req_write), .req_pair(req_pair),
    .req_big(req_big), .req_strict(req_strict),
    .word_idx(word_idx), .reg_wdata(reg_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_write(mem_write),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .done(done), .fault(fault), .fault_code(fault_code)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign reg_wdata = regs[word_idx];
  assign mem_rdata = memw[mem_addr[7:2]];

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_write) memw[mem_addr[7:2]] <= mem_wdata;
  end

  function automatic logic [31:0] lane_map(input logic [31:0] w, input logic big);
    return big ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run_req(input logic [31:0] a, input logic [3:0] n, input bit wr,
                         input bit pair, input bit big, input bit strict);
    int          neff;
    bit          afault;
    logic [31:0] base;
    int          i;
    bit          rdy;
    for (int k = 0; k < 16; k++) regs[k] = $urandom;
    neff   = pair ? 2 : int'(n);
    afault = strict && (a[1:0] != 2'b00);
    base   = {a[31:2], 2'b00};
    @(negedge clk);
    check(req_ready == 1'b1, "R12 idle ready", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = a; req_count = n; req_write = wr;
    req_pair = pair; req_big = big; req_strict = strict;
    @(negedge clk);
    req_valid = 1'b0;
    if (afault || neff == 0) begin
      // R3 / R11: single fault pulse, no beat
      check(fault == 1'b1, afault ? "R3 fault" : "R11 fault", 64'(fault), 64'd1);
      check(fault_code == (afault ? 4'h1 : 4'h2), afault ? "R3 code" : "R11 code",
            64'(fault_code), afault ? 64'd1 : 64'd2);
      check(mem_valid == 1'b0, afault ? "R3 no beat" : "R11 no beat", 64'(mem_valid), 64'd0);
      @(negedge clk);
      check(fault == 1'b0 && mem_valid == 1'b0, "R3 pulse ends", 64'({fault, mem_valid}), 64'd0);
      return;
    end
    i = 0;
    while (i < neff) begin
      check(mem_valid == 1'b1, "R1 beat valid", 64'(mem_valid), 64'd1);
      check(mem_addr == base + 32'(4 * i), (a[1:0] != 0) ? "R4 addr" : "R1 addr",
            64'(mem_addr), 64'(base + 32'(4 * i)));
      check(mem_addr[1:0] == 2'b00, "R2 aligned", 64'(mem_addr[1:0]), 64'd0);
      check(word_idx == CW'(i), "R1 index", 64'(word_idx), 64'(i));
      check(done == 1'b0, "R9 no early done", 64'(done), 64'd0);
      check(mem_write == wr, "R1 direction", 64'(mem_write), 64'(wr));
      if (wr)
        check(mem_wdata == lane_map(regs[i], big), big ? "R6 store lanes" : "R5 store lanes",
              64'(mem_wdata), 64'(lane_map(regs[i], big)));
      rdy = ($urandom % 4) != 0;
      mem_ready = rdy;
      if (!rdy) begin
        // R12: request offered mid-run must be ignored
        req_valid = 1'b1; req_addr = $urandom; req_count = 4'd1; req_write = ~wr;
        check(req_ready == 1'b0, "R12 busy", 64'(req_ready), 64'd0);
      end
      #1;
      if (rdy && !wr) begin
        check(ld_valid == 1'b1, "R7 ld_valid", 64'(ld_valid), 64'd1);
        check(ld_data == lane_map(memw[mem_addr[7:2]], big), "R7 load lanes",
              64'(ld_data), 64'(lane_map(memw[mem_addr[7:2]], big)));
      end
      @(negedge clk);
      req_valid = 1'b0;
      mem_ready = 1'b0;
      if (!rdy)
        check(mem_addr == base + 32'(4 * i) && word_idx == CW'(i), "R8 stall hold",
              64'(mem_addr), 64'(base + 32'(4 * i)));
      if (rdy) i++;
    end
    check(done == 1'b1, "R9 done", 64'(done), 64'd1);
    check(req_ready == 1'b1 && mem_valid == 1'b0, "R9 ready after done",
          64'({req_ready, mem_valid}), 64'd2);
    check(fault == 1'b0, "R9 no fault", 64'(fault), 64'd0);
    @(negedge clk);
    check(done == 1'b0, "R9 single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) memw[k] = $urandom;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_count = '0;
    req_write = 1'b0; req_pair = 1'b0; req_big = 1'b0; req_strict = 1'b0;
    mem_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(mem_valid == 1'b0 && done == 1'b0 && fault == 1'b0, "R12 reset state",
          64'({mem_valid, done, fault}), 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);

    run_req(32'h0000_0010, 4'd3, 1'b1, 1'b0, 1'b0, 1'b1); // R5 store LE
    run_req(32'h0000_0040, 4'd3, 1'b1, 1'b0, 1'b1, 1'b1); // R6 store BE
    run_req(32'h0000_0010, 4'd3, 1'b0, 1'b0, 1'b0, 1'b0); // R7 load LE
    run_req(32'h0000_0040, 4'd3, 1'b0, 1'b0, 1'b1, 1'b0); // R7 load BE
    run_req(32'h0000_0023, 4'd2, 1'b0, 1'b0, 1'b0, 1'b1); // R3 strict misaligned
    run_req(32'h0000_0022, 4'd0, 1'b1, 1'b0, 1'b0, 1'b1); // R3 priority over R11
    run_req(32'h0000_0023, 4'd2, 1'b1, 1'b0, 1'b1, 1'b0); // R4 relaxed misaligned
    run_req(32'h0000_0080, 4'd7, 1'b1, 1'b1, 1'b0, 1'b1); // R10 pair forces 2
    run_req(32'h0000_0080, 4'd0, 1'b0, 1'b1, 1'b1, 1'b1); // R10 pair with zero count
    run_req(32'h0000_0030, 4'd0, 1'b0, 1'b0, 1'b0, 1'b1); // R11 empty
    run_req(32'h0000_0000, 4'd15, 1'b1, 1'b0, 1'b1, 1'b0); // R1 max count

    for (int t = 0; t < 60; t++) begin
      run_req($urandom % 256, 4'($urandom), 1'($urandom), ($urandom % 5) == 0,
              1'($urandom), 1'($urandom));
    end

    repeat (2) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule